// File: doc/BRIEF.md
# Daisy-chain serial frame receiver with idle-timeout latch

This block is the receive end of a two-wire serial link used to load LED driver devices connected in a chain. A serial clock and a serial data line arrive from the upstream device or host. Both lines pass through synchronizers into the local system clock domain. Each rising edge of the serial clock shifts one data bit into a 40-bit frame register. The oldest bit of that register drives the serial data output, so bits beyond the first 40 pass on to the next device. In a chain, the frame meant for the farthest device is therefore sent first, and all frames follow one another with no pause.

The block has no load strobe. A counter running on the system clock measures how long the serial clock has been idle. When it reaches a programmable limit, the block raises a one-cycle latch pulse. On that pulse, the top four bits of the frame register, which are the first four bits shifted in, select a destination. One value loads the 36-bit payload into a function-control register. Another value loads it into three 12-bit grayscale channel values. Any other value discards the frame. One bit of the function-control register is brought out as the auto-repeat mode enable.

A pause longer than the limit, whether in the middle of a frame or between frames, fires the latch early. The block then decodes whatever the frame register holds at that moment.

Top module: `chain_rx_latch`

## Requirements
- R1: The data input, seen through a two-flop synchronizer, is shifted into bit 0 of the 40-bit frame register on each rising edge of the synchronized serial clock. The register moves toward bit 39, so the first bit shifted in ends in bit 39. The register changes on no other cycle.
- R2: `sdata_out` always equals bit 39 of the frame register, which is the oldest bit held. A stream longer than 40 bits therefore leaves on `sdata_out`, bit for bit and in order, starting with its first bit.
- R3: Once a serial clock rising edge has been seen, `IDLE_CYCLES` system clock cycles with no further edge raise `latch_pulse` for exactly one cycle. No further pulse follows until another edge arrives, however long the idle lasts.
- R4: No latch pulse occurs while consecutive serial clock edges are closer together than the timeout, so frames sent back to back latch only once, after the last bit.
- R5: A latch with header 1111 (frame bits 39:36) loads frame bits 35:0 into `fc_data` on the cycle after the pulse. `fc_data` changes at no other time.
- R6: A latch with header 0000 loads the grayscale channels on the cycle after the pulse: `gs_ch2` from frame bits 35:24, `gs_ch1` from bits 23:12 and `gs_ch0` from bits 11:0.
- R7: A latch with any header other than 0000 or 1111 leaves `fc_data`, all grayscale channels and `auto_repeat` unchanged.
- R8: `auto_repeat` equals bit 0 of the function-control payload (frame bit 0 of the last accepted 1111 frame).
- R9: A synchronous active-high reset clears the frame register, all output registers and the idle state. After reset, no latch pulse occurs until a serial clock edge has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from upstream, asynchronous |
| sdata_in | input | 1 | Serial data from upstream, asynchronous |
| sdata_out | output | 1 | Oldest frame bit, passed on to the next device |
| latch_pulse | output | 1 | One-cycle pulse at the end of an idle period |
| fc_data | output | 36 | Function-control register |
| auto_repeat | output | 1 | Auto-repeat mode enable, function-control bit 0 |
| gs_ch0 | output | 12 | Grayscale channel 0 |
| gs_ch1 | output | 12 | Grayscale channel 1 |
| gs_ch2 | output | 12 | Grayscale channel 2 |

## Verification
A wrong bit in the frame register shows up at once on `sdata_out`, and it appears in the decoded registers one cycle after the next latch pulse. The bench keeps its own 40-bit model of the shifted stream and compares `sdata_out` with the model's oldest bit before every serial clock edge.

A counter that does not restart on each edge shows up as an extra latch pulse in the middle of a stream. A counter that fails to disarm shows up as a second pulse during a long idle. The scoreboard reports both as unexpected pulses within one timeout period. A wrong header decision changes the function-control or grayscale outputs one cycle after the pulse, where the monitor compares them with the values predicted from the model.

// File: rtl/crl_pkg.sv
package crl_pkg;
  typedef enum logic [1:0] {
    HDR_GS  = 2'd0,
    HDR_FC  = 2'd1,
    HDR_BAD = 2'd2
  } hdr_kind_e;
endpackage

// File: rtl/crl_sync.sv
module crl_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        q[i]      <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/crl_shift.sv
module crl_shift #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], din};
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> frame[0] == $past(din));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(frame));
endmodule

// File: rtl/crl_idle.sv
module crl_idle #(
  parameter int IDLE_CYCLES = 3_200_000
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  output logic latch
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      latch   <= 1'b0;
    end else begin
      latch <= 1'b0;
      if (edge_seen) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == LAST) begin
          latch   <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    latch |=> !latch);
  // R4
  edge_blocks_latch_chk: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> !latch);
endmodule

// File: rtl/crl_decode.sv
module crl_decode
  import crl_pkg::*;
#(
  parameter int FRAME_W = 40,
  parameter int HDR_W   = 4,
  parameter int CH_W    = 12,
  parameter int AR_BIT  = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       latch,
  input  logic [FRAME_W-1:0]         frame,
  output logic [FRAME_W-HDR_W-1:0]   fc_q,
  output logic [FRAME_W-HDR_W-1:0]   gs_q,
  output logic                       ar_q
);
  localparam int PAY_W = FRAME_W - HDR_W;
  localparam int CH_N  = PAY_W / CH_W;

  logic [HDR_W-1:0] hdr;
  logic [PAY_W-1:0] pay;
  hdr_kind_e        kind;

  assign hdr = frame[FRAME_W-1 -: HDR_W];
  assign pay = frame[PAY_W-1:0];

  always_comb begin
    if (hdr == {HDR_W{1'b1}})      kind = HDR_FC;
    else if (hdr == {HDR_W{1'b0}}) kind = HDR_GS;
    else                           kind = HDR_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fc_q <= '0;
      ar_q <= 1'b0;
    end else if (latch && kind == HDR_FC) begin
      fc_q <= pay;
      ar_q <= pay[AR_BIT];
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                          gs_q[c*CH_W +: CH_W] <= '0;
      else if (latch && kind == HDR_GS) gs_q[c*CH_W +: CH_W] <= pay[c*CH_W +: CH_W];
    end
  end

  // R7
  bad_hdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch && kind == HDR_BAD) |=> ($stable(fc_q) && $stable(gs_q) && $stable(ar_q)));
  // R5
  fc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(fc_q));
  // R6
  gs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(gs_q));
endmodule

// File: rtl/chain_rx_latch.sv
module chain_rx_latch #(
  parameter int FRAME_W     = 40,
  parameter int HDR_W       = 4,
  parameter int CH_W        = 12,
  parameter int AR_BIT      = 0,
  parameter int IDLE_CYCLES = 3_200_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclk_in,
  input  logic                     sdata_in,
  output logic                     sdata_out,
  output logic                     latch_pulse,
  output logic [FRAME_W-HDR_W-1:0] fc_data,
  output logic                     auto_repeat,
  output logic [CH_W-1:0]          gs_ch0,
  output logic [CH_W-1:0]          gs_ch1,
  output logic [CH_W-1:0]          gs_ch2
);
  localparam int PAY_W = FRAME_W - HDR_W;

  logic [1:0]         sync_q;
  logic               sclk_prev_q;
  logic               rise;
  logic [FRAME_W-1:0] frame_q;
  logic [PAY_W-1:0]   gs_flat;

  crl_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_in, sdata_in}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev_q <= 1'b0;
    else     sclk_prev_q <= sync_q[1];
  end

  assign rise = sync_q[1] & ~sclk_prev_q;

  crl_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rise),
    .din      (sync_q[0]),
    .frame    (frame_q)
  );

  assign sdata_out = frame_q[FRAME_W-1];

  crl_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .edge_seen (rise),
    .latch     (latch_pulse)
  );

  crl_decode #(
    .FRAME_W (FRAME_W),
    .HDR_W   (HDR_W),
    .CH_W    (CH_W),
    .AR_BIT  (AR_BIT)
  ) u_dec (
    .clk   (clk),
    .rst   (rst),
    .latch (latch_pulse),
    .frame (frame_q),
    .fc_q  (fc_data),
    .gs_q  (gs_flat),
    .ar_q  (auto_repeat)
  );

  assign gs_ch0 = gs_flat[0*CH_W +: CH_W];
  assign gs_ch1 = gs_flat[1*CH_W +: CH_W];
  assign gs_ch2 = gs_flat[2*CH_W +: CH_W];

  // R8
  ar_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(auto_repeat) |-> $past(latch_pulse));
endmodule

// File: tb/chain_rx_latch_test.sv
module chain_rx_latch_test;
  localparam int IDLE = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_in = 1'b0;
  logic sdata_in = 1'b0;
  logic sdata_out, latch_pulse, auto_repeat;
  logic [35:0] fc_data;
  logic [11:0] gs_ch0, gs_ch1, gs_ch2;

  always #2.5 clk = ~clk;

  chain_rx_latch #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .latch_pulse(latch_pulse), .fc_data(fc_data),
    .auto_repeat(auto_repeat), .gs_ch0(gs_ch0), .gs_ch1(gs_ch1), .gs_ch2(gs_ch2)
  );

  typedef struct packed {
    logic [35:0] fc;
    logic [35:0] gs;
  } exp_t;

  exp_t        sb_q[$];
  logic [39:0] mdl = '0;
  logic [35:0] exp_fc = '0;
  logic [35:0] exp_gs = '0;
  int total = 0;
  int bad = 0;
  int pulses = 0;
  int pushes = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sclk_in = 1'b0;
    sdata_in = b;
    repeat (4) @(negedge clk);
    // R2: oldest bit leaves first
    check(sdata_out === mdl[39], "R2 sdata_out", {79'd0, sdata_out}, {79'd0, mdl[39]});
    sclk_in = 1'b1;
    mdl = {mdl[38:0], b};
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [3:0] h, input logic [35:0] p);
    logic [39:0] f;
    f = {h, p};
    for (int i = 39; i >= 0; i--) send_bit(f[i]);
  endtask

  // scoreboard push: predicted register state after the coming latch, then idle
  task automatic idle_latch();
    exp_t e;
    if (mdl[39:36] == 4'hF) exp_fc = mdl[35:0];
    else if (mdl[39:36] == 4'h0) exp_gs = mdl[35:0];
    e.fc = exp_fc;
    e.gs = exp_gs;
    sb_q.push_back(e);
    pushes++;
    repeat (IDLE + 20) @(negedge clk);
    // R4 / R3: exactly one pulse per idle period
    check(pulses == pushes, "R3 pulse count", 80'(pulses), 80'(pushes));
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (latch_pulse) begin
        pulses++;
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected latch", 80'd1, 80'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          // R5
          check(fc_data === e.fc, "R5 fc_data", {44'd0, fc_data}, {44'd0, e.fc});
          // R6 / R7
          check({gs_ch2, gs_ch1, gs_ch0} === e.gs, "R6 grayscale",
                {44'd0, gs_ch2, gs_ch1, gs_ch0}, {44'd0, e.gs});
          // R8
          check(auto_repeat === e.fc[0], "R8 auto_repeat", {79'd0, auto_repeat}, {79'd0, e.fc[0]});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 80'd0, 80'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check({sdata_out, latch_pulse, auto_repeat, fc_data, gs_ch2, gs_ch1, gs_ch0} === '0,
          "R9 reset outputs", {6'd0, sdata_out, latch_pulse, auto_repeat, fc_data, gs_ch2, gs_ch1, gs_ch0}, 80'd0);
    repeat (IDLE * 3) @(negedge clk);
    // R9: no latch before any serial edge
    check(pulses == 0, "R9 no latch after reset", 80'(pulses), 80'd0);

    // R5 R8: function control with auto-repeat set
    send_frame(4'hF, 36'h0_0000_01FF);
    idle_latch();
    // R6: grayscale all ones, then distinct channels
    send_frame(4'h0, 36'hFFF_FFF_FFF);
    idle_latch();
    send_frame(4'h0, 36'h123_456_789);
    idle_latch();
    // R7: unknown header ignored
    send_frame(4'hA, 36'h5A5_A5A_5A5);
    idle_latch();
    // R2 R4: two frames back to back, only the last one latches
    send_frame(4'hF, 36'h0_0000_0100);
    send_frame(4'h0, 36'hABC_DEF_012);
    idle_latch();
    // R3: long idle gives no second pulse
    repeat (IDLE * 4) @(negedge clk);
    check(pulses == pushes, "R3 single pulse on long idle", 80'(pulses), 80'(pushes));
    // R5 R8: auto-repeat cleared
    send_frame(4'hF, 36'h0_0000_0100);
    idle_latch();
    // R3: premature latch from a gap mid-frame
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    idle_latch();
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    idle_latch();
    // R1 R6: fresh grayscale frame after a partial one
    send_frame(4'h0, 36'h0F0_F0F_00F);
    idle_latch();

    check(sb_q.size() == 0, "R3 scoreboard drained", 80'(sb_q.size()), 80'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule